// File: doc/BRIEF.md
# Byte-Serial Load/Store Unit

This unit carries out the memory-access group of a 16-bit processor against a memory that is one byte wide and spans 64K addresses. The memory never stalls. A 16-bit value therefore crosses the bus as two byte transfers on consecutive cycles. The low byte sits at the lower address. The unit reads the opcode to pick one of four ways of forming the address: through a pointer register, through a pointer that is bumped after the access, as the stack pointer plus an unsigned byte offset, or as a 16-bit absolute address. The opcode also picks the width, the direction and the registers.

The register file lives outside the unit. The unit reads all four registers through a flat input bus. It writes back through a single write port, and it forwards that port's value to its own reads. An instruction starts with a one-cycle `start` pulse that carries the opcode. Any offset or address bytes arrive on `opnd_byte` in the cycles that follow. An instruction takes exactly as many cycles as the bytes it moves, counting the opcode.

Top module: `bytebus_lsu`

## Requirements
- R1: The unit takes an opcode only if bits [7:6] are 10. Bits [5:4] give the mode: 0 pointer, 1 pointer with post-bump, 2 stack-relative, 3 absolute. Bit 3 set means store and bit 2 set means byte width. In modes 0 and 1, bit 1 picks the pointer (clear gives register 2, set gives register 3) and bit 0 picks data register 0 or 1. In modes 2 and 3, bits [1:0] pick data register 0 to 3.
- R2: Call the `start` cycle cycle 0. `busy` is high from cycle 1 for one cycle fewer than the bytes the instruction accesses. This gives 1+width cycles for the pointer modes, 2+width for stack-relative and 3+width for absolute, where width is 1 for byte and 2 for word. Operand bytes are sampled in cycle 1 and, for absolute mode, in cycle 2.
- R3: A word goes to the effective address and the effective address plus 1 in consecutive cycles. The low byte uses the first address and the high byte the second, for both loads and stores.
- R4: A byte load writes the register with bits [15:8] cleared. A byte store writes a single address and leaves the next byte untouched.
- R5: `mem_rdata` carries the byte addressed in the previous cycle. A load result appears on the write port (`rf_we` high) in the cycle after the last address cycle, and in no earlier cycle.
- R6: In post-bump mode the access uses the old pointer value. The pointer is written back as old+1 for a byte or old+2 for a word, in cycle 1.
- R7: The stack-relative address is the stack pointer plus the zero-extended offset byte, modulo 2^16.
- R8: The absolute address arrives low byte first. A word at address 0xFFFF places its high byte at 0x0000.
- R9: An opcode outside 0x80–0xBF and a `start` pulse while `busy` is high are both ignored: no memory write, no register write, no change in `busy`.
- R10: A register read in a cycle where the write port is writing that same register sees the new value. This lets a store issued in a load's tail cycle store the loaded data.
- R11: While reset is held and just after it, `busy`, `mem_we` and `rf_we` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Opcode valid for one cycle |
| opcode | input | 8 | Instruction opcode |
| opnd_byte | input | 8 | Offset or address byte, one per cycle |
| busy | output | 1 | Instruction in progress |
| mem_addr | output | 16 | Byte address |
| mem_wdata | output | 8 | Byte to write |
| mem_we | output | 1 | Write enable |
| mem_rdata | input | 8 | Byte read, addressed in the previous cycle |
| gpr_flat | input | 64 | Registers 3..0 concatenated, register 0 in bits [15:0] |
| sp | input | 16 | Stack pointer |
| rf_we | output | 1 | Register write enable |
| rf_wsel | output | 2 | Register to write |
| rf_wdata | output | 16 | Value to write |

## Verification
Each mode is tried with both widths and both directions. Distinct byte patterns in the high and low halves show any swapped byte order or a missing zero-fill.

The offset 0xF0 separates an unsigned stack-relative offset from a signed one. The absolute word store at 0xFFFF separates modulo-2^16 wrap from an address carried past 16 bits.

The remaining patterns each isolate one fault:
- Pointer-selection bits set to 1 catch a decode stuck at the default registers.
- Back-to-back load then store of the same register catches a missing forward.
- Opcodes outside the group, and `start` pulses held while busy, catch an accept path that is too loose.

// File: rtl/lsu_pkg.sv
package lsu_pkg;
  localparam int OPW  = 8;
  localparam int NREG = 4;
  localparam int RSW  = $clog2(NREG);

  typedef enum logic [1:0] {
    AM_PTR   = 2'd0,
    AM_BUMP  = 2'd1,
    AM_SPOFF = 2'd2,
    AM_ABS   = 2'd3
  } amode_e;

  typedef struct packed {
    logic           legal;
    amode_e         mode;
    logic           store;
    logic           bytew;
    logic [RSW-1:0] ptr_sel;
    logic [RSW-1:0] dat_sel;
  } lsop_t;

  typedef enum logic [2:0] {
    ST_IDLE = 3'd0,
    ST_OPA  = 3'd1,
    ST_OPB  = 3'd2,
    ST_XF0  = 3'd3,
    ST_XF1  = 3'd4
  } state_e;
endpackage

// File: rtl/lsu_decode.sv
module lsu_decode
  import lsu_pkg::*;
(
  input  logic [OPW-1:0] opcode,
  output lsop_t          op
);
  always_comb begin
    op.legal   = (opcode[7:6] == 2'b10);
    op.mode    = amode_e'(opcode[5:4]);
    op.store   = opcode[3];
    op.bytew   = opcode[2];
    op.ptr_sel = opcode[1] ? RSW'(3) : RSW'(2);
    if (!opcode[5]) op.dat_sel = RSW'(opcode[0]);
    else            op.dat_sel = opcode[1:0];
  end
endmodule

// File: rtl/lsu_agen.sv
module lsu_agen
  import lsu_pkg::*;
#(
  parameter int AW = 16,
  parameter int BW = 8
) (
  input  amode_e        mode,
  input  logic          bytew,
  input  logic [AW-1:0] ptr,
  input  logic [AW-1:0] sp,
  input  logic [BW-1:0] opnd_cur,
  input  logic [BW-1:0] opnd_lo,
  output logic [AW-1:0] ea,
  output logic [AW-1:0] ptr_next
);
  localparam logic [AW-1:0] STEP_B = AW'(1);
  localparam logic [AW-1:0] STEP_W = AW'(2);

  always_comb begin
    unique case (mode)
      AM_PTR, AM_BUMP: ea = ptr;
      AM_SPOFF:        ea = sp + AW'(opnd_cur);
      default:         ea = AW'({opnd_cur, opnd_lo});
    endcase
    ptr_next = ptr + (bytew ? STEP_B : STEP_W);
  end
endmodule

// File: rtl/lsu_rdasm.sv
module lsu_rdasm #(
  parameter int BW = 8,
  localparam int DW = 2 * BW
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          cap_lo,
  input  logic          fin_word,
  input  logic [BW-1:0] rdata,
  output logic [DW-1:0] value
);
  logic [BW-1:0] lo_q;

  always_ff @(posedge clk) begin
    if (rst)         lo_q <= '0;
    else if (cap_lo) lo_q <= rdata;
  end

  always_comb begin
    if (fin_word) value = {rdata, lo_q};
    else          value = {{BW{1'b0}}, rdata};
  end
endmodule

// File: rtl/bytebus_lsu.sv
module bytebus_lsu
  import lsu_pkg::*;
#(
  parameter int AW = 16,
  parameter int BW = 8,
  localparam int DW = 2 * BW
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               start,
  input  logic [OPW-1:0]     opcode,
  input  logic [BW-1:0]      opnd_byte,
  output logic               busy,
  output logic [AW-1:0]      mem_addr,
  output logic [BW-1:0]      mem_wdata,
  output logic               mem_we,
  input  logic [BW-1:0]      mem_rdata,
  input  logic [NREG*DW-1:0] gpr_flat,
  input  logic [AW-1:0]      sp,
  output logic               rf_we,
  output logic [RSW-1:0]     rf_wsel,
  output logic [DW-1:0]      rf_wdata
);
  state_e         state;
  lsop_t          dec, op_q, cur;
  logic [BW-1:0]  opnd_lo_q, st_hi_q;
  logic           pupd_q, cap_lo_q, fin_q, fin_word_q;
  logic [RSW-1:0] pupd_sel_q, fin_sel_q;
  logic [AW-1:0]  pupd_val_q, ea, ptr_next;
  logic [DW-1:0]  ld_value, ptr_val, dat_val;
  logic [DW-1:0]  rval [NREG];
  logic           do_issue;

  lsu_decode u_dec (.opcode(opcode), .op(dec));

  // Register reads with bypass from the write port.
  for (genvar i = 0; i < NREG; i++) begin : g_fwd
    always_comb begin
      if (rf_we && rf_wsel == RSW'(i)) rval[i] = rf_wdata;
      else                             rval[i] = gpr_flat[i*DW +: DW];
    end
  end

  always_comb begin
    cur      = (state == ST_IDLE) ? dec : op_q;
    ptr_val  = rval[cur.ptr_sel];
    dat_val  = rval[cur.dat_sel];
    do_issue = (state == ST_IDLE && start && dec.legal && !dec.mode[1])
            || (state == ST_OPA && op_q.mode == AM_SPOFF)
            || (state == ST_OPB);
  end

  lsu_agen #(.AW(AW), .BW(BW)) u_agen (
    .mode(cur.mode), .bytew(cur.bytew), .ptr(AW'(ptr_val)), .sp(sp),
    .opnd_cur(opnd_byte), .opnd_lo(opnd_lo_q), .ea(ea), .ptr_next(ptr_next)
  );

  lsu_rdasm #(.BW(BW)) u_rdasm (
    .clk(clk), .rst(rst), .cap_lo(cap_lo_q), .fin_word(fin_word_q),
    .rdata(mem_rdata), .value(ld_value)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      state      <= ST_IDLE;
      op_q       <= '0;
      opnd_lo_q  <= '0;
      mem_addr   <= '0;
      mem_we     <= 1'b0;
      mem_wdata  <= '0;
      st_hi_q    <= '0;
      pupd_q     <= 1'b0;
      pupd_sel_q <= '0;
      pupd_val_q <= '0;
      cap_lo_q   <= 1'b0;
      fin_q      <= 1'b0;
      fin_word_q <= 1'b0;
      fin_sel_q  <= '0;
    end else begin
      pupd_q   <= 1'b0;
      cap_lo_q <= 1'b0;
      fin_q    <= 1'b0;
      if (state == ST_IDLE && start && dec.legal) op_q <= dec;
      if (do_issue) begin
        mem_addr   <= ea;
        mem_we     <= cur.store;
        mem_wdata  <= dat_val[BW-1:0];
        st_hi_q    <= dat_val[DW-1:BW];
        fin_sel_q  <= cur.dat_sel;
        fin_word_q <= !cur.bytew;
        state      <= ST_XF0;
        if (cur.mode == AM_BUMP) begin
          pupd_q     <= 1'b1;
          pupd_sel_q <= cur.ptr_sel;
          pupd_val_q <= ptr_next;
        end
      end else begin
        unique case (state)
          ST_IDLE: if (start && dec.legal) state <= ST_OPA;
          ST_OPA: begin
            opnd_lo_q <= opnd_byte;
            state     <= ST_OPB;
          end
          ST_XF0: begin
            if (!op_q.store) begin
              cap_lo_q <= !op_q.bytew;
              fin_q    <= op_q.bytew;
            end
            if (!op_q.bytew) begin
              mem_addr  <= mem_addr + AW'(1);
              mem_wdata <= st_hi_q;
              state     <= ST_XF1;
            end else begin
              mem_we <= 1'b0;
              state  <= ST_IDLE;
            end
          end
          ST_XF1: begin
            mem_we <= 1'b0;
            fin_q  <= !op_q.store;
            state  <= ST_IDLE;
          end
          default: state <= ST_IDLE;
        endcase
      end
    end
  end

  always_comb begin
    busy = (state != ST_IDLE);
    if (fin_q) begin
      rf_we    = 1'b1;
      rf_wsel  = fin_sel_q;
      rf_wdata = ld_value;
    end else if (pupd_q) begin
      rf_we    = 1'b1;
      rf_wsel  = pupd_sel_q;
      rf_wdata = DW'(pupd_val_q);
    end else begin
      rf_we    = 1'b0;
      rf_wsel  = '0;
      rf_wdata = '0;
    end
  end

  // R3: second byte of a word is one address above the first
  a_r3_hi_follows_lo: assert property (@(posedge clk) disable iff (rst)
    (state == ST_XF1) |-> (mem_addr == $past(mem_addr) + AW'(1)));

  // R4: byte load leaves the upper half zero
  a_r4_byte_zext: assert property (@(posedge clk) disable iff (rst)
    (fin_q && !fin_word_q) |-> (rf_wdata[DW-1:BW] == '0));

  // R9: unsupported opcodes never leave idle
  a_r9_illegal_stays: assert property (@(posedge clk) disable iff (rst)
    (state == ST_IDLE && start && !dec.legal) |=> (state == ST_IDLE));

  // R9: memory writes only in transfer cycles
  a_r9_we_in_xfer: assert property (@(posedge clk) disable iff (rst)
    mem_we |-> (state == ST_XF0 || state == ST_XF1));

  // R6: pointer bump and load result never meet on the write port
  a_r6_no_port_clash: assert property (@(posedge clk) disable iff (rst)
    !(fin_q && pupd_q));

  // R11: outputs quiet right after reset
  a_r11_quiet_after_reset: assert property (@(posedge clk)
    $past(rst) |-> (!busy && !mem_we && !rf_we));
endmodule

// File: tb/tb_bytebus_lsu.sv
module tb_bytebus_lsu;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        start = 1'b0;
  logic [7:0]  opcode = 8'h00;
  logic [7:0]  opnd_byte = 8'h00;
  logic        busy, mem_we, rf_we;
  logic [15:0] mem_addr, rf_wdata;
  logic [7:0]  mem_wdata;
  logic [7:0]  mem_rdata = 8'h00;
  logic [1:0]  rf_wsel;
  logic [15:0] sp = 16'h0000;
  logic [15:0] gpr [4];
  logic [7:0]  mem [4096];
  logic [63:0] gpr_flat;
  int n_chk = 0, n_fail = 0, we_cnt = 0;

  always #4 clk = ~clk;

  assign gpr_flat = {gpr[3], gpr[2], gpr[1], gpr[0]};

  bytebus_lsu dut (
    .clk(clk), .rst(rst), .start(start), .opcode(opcode), .opnd_byte(opnd_byte),
    .busy(busy), .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_we(mem_we),
    .mem_rdata(mem_rdata), .gpr_flat(gpr_flat), .sp(sp),
    .rf_we(rf_we), .rf_wsel(rf_wsel), .rf_wdata(rf_wdata)
  );

  always @(posedge clk) begin
    if (mem_we) mem[mem_addr[11:0]] <= mem_wdata;
    mem_rdata <= mem[mem_addr[11:0]];
    if (rf_we) gpr[rf_wsel] <= rf_wdata;
    if (mem_we) we_cnt <= we_cnt + 1;
  end

  task automatic chk(input string what, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", what, act, exp);
    end
  endtask

  task automatic summary();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
  endtask

  // Issue one instruction; returns the number of busy cycles.
  task automatic run_op(input logic [7:0] op, input logic [7:0] b1,
                        input logic [7:0] b2, output int nbusy);
    int k;
    @(negedge clk); start = 1'b1; opcode = op; opnd_byte = 8'h00;
    @(negedge clk); start = 1'b0; opnd_byte = b1;
    nbusy = 0; k = 1;
    while (busy) begin
      nbusy++;
      @(negedge clk);
      k++;
      opnd_byte = (k == 2) ? b2 : 8'h00;
    end
    repeat (2) @(negedge clk);
  endtask

  task automatic t_reset();
    chk("R11 busy after reset", busy, 1'b0);
    chk("R11 mem_we after reset", mem_we, 1'b0);
    chk("R11 rf_we after reset", rf_we, 1'b0);
  endtask

  task automatic t_ptr_word_load();
    gpr[2] = 16'h0100; gpr[0] = 16'h0000;
    mem[12'h100] = 8'h34; mem[12'h101] = 8'h12;
    @(negedge clk); start = 1'b1; opcode = 8'h80;
    @(negedge clk); start = 1'b0;
    chk("R2 busy c1", busy, 1'b1); chk("R5 no early write c1", rf_we, 1'b0);
    chk("R3 lo address c1", mem_addr, 16'h0100);
    @(negedge clk);
    chk("R2 busy c2", busy, 1'b1); chk("R5 no early write c2", rf_we, 1'b0);
    chk("R3 hi address c2", mem_addr, 16'h0101);
    @(negedge clk);
    chk("R2 idle c3", busy, 1'b0);
    chk("R5 write c3", {rf_we, rf_wsel, rf_wdata}, {1'b1, 2'd0, 16'h1234});
    @(negedge clk);
    chk("R1 R3 r0 loaded", gpr[0], 16'h1234);
  endtask

  task automatic t_ptr_byte_load();
    int nb;
    gpr[3] = 16'h0200; gpr[1] = 16'hFFFF; mem[12'h200] = 8'hA5;
    run_op(8'h87, 8'h00, 8'h00, nb);
    chk("R2 byte ptr busy", nb, 1);
    chk("R1 R4 r1 zero-extended via r3", gpr[1], 16'h00A5);
  endtask

  task automatic t_ptr_stores();
    int nb;
    gpr[3] = 16'h0300; gpr[1] = 16'hBEEF;
    run_op(8'h8B, 8'h00, 8'h00, nb);
    chk("R3 store lo", mem[12'h300], 8'hEF);
    chk("R3 store hi", mem[12'h301], 8'hBE);
    gpr[2] = 16'h0310; gpr[0] = 16'h7788; mem[12'h311] = 8'h55;
    run_op(8'h8C, 8'h00, 8'h00, nb);
    chk("R4 byte store", mem[12'h310], 8'h88);
    chk("R4 neighbour intact", mem[12'h311], 8'h55);
  endtask

  task automatic t_bump();
    int nb;
    gpr[2] = 16'h0400; mem[12'h400] = 8'h0D; mem[12'h401] = 8'hF0;
    run_op(8'h91, 8'h00, 8'h00, nb);
    chk("R6 word via old pointer", gpr[1], 16'hF00D);
    chk("R6 pointer +2", gpr[2], 16'h0402);
    gpr[3] = 16'h0410; gpr[0] = 16'h1166;
    run_op(8'h9E, 8'h00, 8'h00, nb);
    chk("R6 byte store old pointer", mem[12'h410], 8'h66);
    chk("R6 pointer +1", gpr[3], 16'h0411);
  endtask

  task automatic t_spoff();
    int nb;
    sp = 16'h0500; mem[12'h5F0] = 8'h11; mem[12'h5F1] = 8'h22;
    mem[12'h4F0] = 8'h99; mem[12'h4F1] = 8'h99;
    run_op(8'hA3, 8'hF0, 8'h00, nb);
    chk("R2 stack word busy", nb, 3);
    chk("R7 unsigned offset", gpr[3], 16'h2211);
    sp = 16'hFFF8; gpr[2] = 16'h4321;
    run_op(8'hAA, 8'h10, 8'h00, nb);
    chk("R7 wrap lo", mem[12'h008], 8'h21);
    chk("R7 wrap hi", mem[12'h009], 8'h43);
  endtask

  task automatic t_abs();
    int nb;
    mem[12'h634] = 8'h78; mem[12'h635] = 8'h56;
    run_op(8'hB2, 8'h34, 8'h06, nb);
    chk("R2 absolute word busy", nb, 4);
    chk("R8 absolute load", gpr[2], 16'h5678);
    gpr[3] = 16'hCAFE;
    run_op(8'hBB, 8'hFF, 8'hFF, nb);
    chk("R8 top byte", mem[12'hFFF], 8'hFE);
    chk("R8 wrapped byte", mem[12'h000], 8'hCA);
    gpr[3] = 16'h1234; mem[12'h640] = 8'h80;
    run_op(8'hB7, 8'h40, 8'h06, nb);
    chk("R2 absolute byte busy", nb, 3);
    chk("R4 absolute byte load", gpr[3], 16'h0080);
  endtask

  task automatic t_ignore();
    int nb, w0;
    w0 = we_cnt; gpr[0] = 16'hAAAA;
    run_op(8'h40, 8'h00, 8'h00, nb);
    chk("R9 illegal busy", nb, 0);
    run_op(8'hC8, 8'h00, 8'h00, nb);
    chk("R9 illegal busy upper", nb, 0);
    chk("R9 illegal no write", we_cnt - w0, 0);
    chk("R9 illegal reg intact", gpr[0], 16'hAAAA);
    mem[12'h700] = 8'h01; mem[12'h701] = 8'h02; gpr[2] = 16'h0710;
    @(negedge clk); start = 1'b1; opcode = 8'hB0; opnd_byte = 8'h00;
    @(negedge clk); opcode = 8'h88; opnd_byte = 8'h00;
    @(negedge clk); opnd_byte = 8'h07;
    @(negedge clk); opnd_byte = 8'h00;
    @(negedge clk); start = 1'b0;
    repeat (3) @(negedge clk);
    chk("R9 busy start ignored, load ok", gpr[0], 16'h0201);
    chk("R9 busy start no write", we_cnt - w0, 0);
  endtask

  task automatic t_forward();
    gpr[2] = 16'h0800; gpr[3] = 16'h0820; gpr[0] = 16'h0000;
    mem[12'h800] = 8'hC3; mem[12'h801] = 8'h5A;
    @(negedge clk); start = 1'b1; opcode = 8'h80;
    @(negedge clk); start = 1'b0;
    @(negedge clk);
    @(negedge clk); start = 1'b1; opcode = 8'h8A;
    @(negedge clk); start = 1'b0;
    repeat (4) @(negedge clk);
    chk("R10 forwarded lo", mem[12'h820], 8'hC3);
    chk("R10 forwarded hi", mem[12'h821], 8'h5A);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    summary();
    $finish;
  end

  initial begin
    for (int i = 0; i < 4096; i++) mem[i] = 8'h00;
    for (int i = 0; i < 4; i++) gpr[i] = 16'h0000;
    repeat (3) @(negedge clk);
    t_reset();
    rst = 1'b0;
    @(negedge clk);
    t_reset();
    t_ptr_word_load();
    t_ptr_byte_load();
    t_ptr_stores();
    t_bump();
    t_spoff();
    t_abs();
    t_ignore();
    t_forward();
    summary();
    $finish;
  end
endmodule